// File: doc/BRIEF.md
# Paged RAM write-protect controller

This block is a small on-chip RAM split into equal pages. Each page has its own write-enable bit in an 8-bit control register. The register is reached over a simple register bus. The RAM has its own 32-bit memory bus with per-byte strobes. A write that reaches a page whose enable bit is clear is dropped without any error, and the array keeps its old contents.

Each page posts its most recent write into a one-entry buffer. A buffered write reaches the array only when a later read or write to the same page arrives. At that moment the write is checked against the enable bit then in force. As a result, a write still waiting in the buffer when its page is protected is lost. Software that protects a page must first touch that page once to flush it.

The register has two resets. The power-on reset sets every enable bit. The manual reset clears the buffers and the bus outputs but keeps the protection settings. With the default parameters the RAM has 4 pages of 64 words. Setting `PAGE_AW` to 11 gives 8 KB pages, with page 3 at the top of the window.

Top module: `paged_wp_ram`

## Requirements
- R1: A power-on reset (`rst_n` low at a clock edge) sets the control register to 0xFF, empties every page buffer, and drives `reg_rdata`, `reg_err` and `mem_rdata` to zero.
- R2: A manual reset (`mrst_n` low, `rst_n` high) leaves the control register unchanged. It discards every pending buffered write and clears `reg_rdata`, `reg_err` and `mem_rdata`.
- R3: A byte-sized register read (`reg_size` = 0) returns, in the following cycle, bits 7:4 as 1 and bits 3:0 as the page enables. Written values of bits 7:4 have no effect.
- R4: A byte-sized register write updates the enables from `reg_wdata[3:0]` at the next clock edge. Bit i enables page i, where 1 allows writes and 0 blocks them. A register write of any other size (1 = half, 2 = word) changes nothing.
- R5: A register read whose size is not byte returns 0x00 and raises `reg_err` for exactly the one following cycle.
- R6: The page of a memory access is given by the top two bits of the word address `mem_addr`. Page 3 is the highest quarter of the window.
- R7: A read issued in cycle N shows its data on `mem_rdata` in cycle N+1, and `mem_rdata` holds until the next read.
- R8: A buffered write is committed, or silently dropped, according to the page's enable bit at the time of commit, not at the time it was issued. A dropped write leaves the array unchanged.
- R9: On an enabled page, a write accepted in cycle N is returned by a read of the same word in cycle N+1.
- R10: A RAM access in the same cycle as a register write uses the enable value from before that write.
- R11: Only the bytes selected by `mem_be` are written; the other bytes of the word keep their value.
- R12: A page buffer is committed only by an access to its own page. Accesses to other pages leave it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| mrst_n | input | 1 | Synchronous active-low manual reset, keeps the protection settings |
| reg_sel | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = register write, 0 = register read |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after the request |
| reg_err | output | 1 | One-cycle strobe for a read that is not byte-sized |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = memory write, 0 = memory read |
| mem_addr | input | 8 | Word address; the top bits select the page |
| mem_be | input | 4 | Byte strobes for writes |
| mem_wdata | input | 32 | Memory write data |
| mem_rdata | output | 32 | Memory read data, one cycle after the request |

## Verification
Most wrong internal states in this block stay hidden until the affected page is accessed again. A buffer that was lost, committed too early or committed to the wrong page only shows on `mem_rdata` in the cycle after the next read of that word. The bench therefore always follows a suspect sequence with a read of the exact word, where either the old or the new value is known. A wrong enable bit shows on `reg_rdata` one cycle after a byte read. It also shows on the data path, because a write to that page is dropped or kept at its next commit.

// File: rtl/pwp_pkg.sv
// Shared constants for the paged write-protect RAM.
// Assumes a 32-bit data path with byte strobes and a byte-wide control register.
package pwp_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int REG_W  = 8;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/wp_ctrl_reg.sv
// Write-enable control register.
// Holds one enable bit per page; bits above NUM_PAGES read as 1.
// Only power-on reset initialises the enables; the manual reset clears
// only the read-data and error outputs. Assumes NUM_PAGES <= 8.
module wp_ctrl_reg
    import pwp_pkg::*;
#(
    parameter int NUM_PAGES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mrst_n,
    input  logic                 reg_sel,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_size,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 reg_err,
    output logic [NUM_PAGES-1:0] page_en
);
    logic                 wr_ok;
    logic                 wr_bad;
    logic                 rd_ok;
    logic                 rd_bad;
    logic [REG_W-1:0]     view;
    logic [NUM_PAGES-1:0] en_q;
    logic                 unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_W-1:NUM_PAGES];

    // Decode the register access by direction and size.
    always_comb begin
        wr_ok  = reg_sel && reg_wr && (reg_size == SZ_BYTE);
        wr_bad = reg_sel && reg_wr && (reg_size != SZ_BYTE);
        rd_ok  = reg_sel && !reg_wr && (reg_size == SZ_BYTE);
        rd_bad = reg_sel && !reg_wr && (reg_size != SZ_BYTE);
    end

    // Build the visible register value: enables below, reserved ones above.
    always_comb begin
        for (int i = 0; i < REG_W; i++) begin
            view[i] = (i < NUM_PAGES) ? en_q[i] : 1'b1;
        end
    end

    // Enable bits: set by power-on reset only, loaded by byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '1;
        end else if (wr_ok) begin
            en_q <= reg_wdata[NUM_PAGES-1:0];
        end
    end

    // Registered read data and the access-error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !mrst_n) begin
            reg_rdata <= '0;
            reg_err   <= 1'b0;
        end else begin
            reg_rdata <= rd_ok ? view : '0;
            reg_err   <= rd_bad;
        end
    end

    assign page_en = en_q;

    a_r4_nonbyte_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> $stable(page_en));

    a_r2_mrst_keeps_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrst_n && !wr_ok) |=> $stable(page_en));

    a_r5_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> (reg_rdata == '0));

    a_r5_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n || !mrst_n)
        reg_err |-> $past(rd_bad));
endmodule

// File: rtl/wp_post_buf.sv
// One-entry posted-write buffer for a single page.
// On any access to its page it offers the held entry for commit (gated by
// the page enable in force now) and then captures a new write, if any.
// Assumes at most one memory access per cycle.
module wp_post_buf
    import pwp_pkg::*;
#(
    parameter int PAGE_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mrst_n,
    input  logic               hit,
    input  logic               wr,
    input  logic               en,
    input  logic [PAGE_AW-1:0] in_addr,
    input  logic [BE_W-1:0]    in_be,
    input  logic [DATA_W-1:0]  in_data,
    output logic               valid,
    output logic               commit,
    output logic [PAGE_AW-1:0] ent_addr,
    output logic [BE_W-1:0]    ent_be,
    output logic [DATA_W-1:0]  ent_data
);
    logic               valid_q;
    logic [PAGE_AW-1:0] addr_q;
    logic [BE_W-1:0]    be_q;
    logic [DATA_W-1:0]  data_q;

    // Hold the latest write to this page until the next access to it.
    always_ff @(posedge clk) begin
        if (!rst_n || !mrst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            data_q  <= '0;
        end else if (hit) begin
            valid_q <= wr;
            if (wr) begin
                addr_q <= in_addr;
                be_q   <= in_be;
                data_q <= in_data;
            end
        end
    end

    // Offer the entry to the array only when the page is enabled right now.
    assign commit   = hit && valid_q && en;
    assign valid    = valid_q;
    assign ent_addr = addr_q;
    assign ent_be   = be_q;
    assign ent_data = data_q;

    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n || !mrst_n)
        !hit |=> ($stable(valid_q) && $stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/wp_store.sv
// Word array with byte-strobed write and combinational read.
// Assumes one write per cycle; contents are not reset.
module wp_store
    import pwp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BE_W-1:0]   wbe,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    // Write only the strobed bytes of the addressed word.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wbe[b]) mem[waddr][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    // Read the addressed word as it stands before this cycle's write.
    assign rdata = mem[raddr];
endmodule

// File: rtl/paged_wp_ram.sv
// Paged RAM with a per-page write gate and per-page posted writes.
// The top address bits select the page. A read returns the array word
// overlaid with the page's buffered entry when that entry commits in the
// same cycle, so the result matches the array after the commit.
// Assumes NUM_PAGES is a power of two, no larger than 8.
module paged_wp_ram
    import pwp_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int PAGE_AW   = 6,
    localparam int SEL_W    = $clog2(NUM_PAGES),
    localparam int ADDR_W   = SEL_W + PAGE_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [1:0]        reg_size,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              reg_err,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [3:0]        mem_be,
    input  logic [31:0]       mem_wdata,
    output logic [31:0]       mem_rdata
);
    logic [NUM_PAGES-1:0]  page_en;
    logic [SEL_W-1:0]      acc_page;
    logic [PAGE_AW-1:0]    acc_off;
    logic [NUM_PAGES-1:0]  hit;
    logic [NUM_PAGES-1:0]  ent_valid;
    logic [NUM_PAGES-1:0]  commit;
    logic [PAGE_AW-1:0]    ent_addr [NUM_PAGES];
    logic [BE_W-1:0]       ent_be   [NUM_PAGES];
    logic [DATA_W-1:0]     ent_data [NUM_PAGES];
    logic                  st_we;
    logic [ADDR_W-1:0]     st_waddr;
    logic [BE_W-1:0]       st_wbe;
    logic [DATA_W-1:0]     st_wdata;
    logic [DATA_W-1:0]     raw_word;
    logic [DATA_W-1:0]     merged;
    logic                  rd_req;

    assign acc_page = mem_addr[ADDR_W-1 -: SEL_W];
    assign acc_off  = mem_addr[PAGE_AW-1:0];
    assign rd_req   = mem_req && !mem_we;

    wp_ctrl_reg #(.NUM_PAGES(NUM_PAGES)) u_reg (
        .clk(clk), .rst_n(rst_n), .mrst_n(mrst_n),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_size(reg_size),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .page_en(page_en)
    );

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        assign hit[p] = mem_req && (acc_page == SEL_W'(p));

        wp_post_buf #(.PAGE_AW(PAGE_AW)) u_buf (
            .clk(clk), .rst_n(rst_n), .mrst_n(mrst_n),
            .hit(hit[p]), .wr(mem_we), .en(page_en[p]),
            .in_addr(acc_off), .in_be(mem_be), .in_data(mem_wdata),
            .valid(ent_valid[p]), .commit(commit[p]),
            .ent_addr(ent_addr[p]), .ent_be(ent_be[p]), .ent_data(ent_data[p])
        );
    end

    // Route the single committing page buffer to the array write port.
    always_comb begin
        st_we    = 1'b0;
        st_waddr = '0;
        st_wbe   = '0;
        st_wdata = '0;
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (commit[p]) begin
                st_we    = 1'b1;
                st_waddr = {SEL_W'(p), ent_addr[p]};
                st_wbe   = ent_be[p];
                st_wdata = ent_data[p];
            end
        end
    end

    wp_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(st_we), .waddr(st_waddr), .wbe(st_wbe),
        .wdata(st_wdata), .raddr(mem_addr), .rdata(raw_word)
    );

    // Overlay the same-word entry that commits this cycle onto the array word.
    always_comb begin
        merged = raw_word;
        if (commit[acc_page] && (ent_addr[acc_page] == acc_off)) begin
            for (int b = 0; b < BE_W; b++) begin
                if (ent_be[acc_page][b]) merged[8*b +: 8] = ent_data[acc_page][8*b +: 8];
            end
        end
    end

    // Register read data; it holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n || !mrst_n) begin
            mem_rdata <= '0;
        end else if (rd_req) begin
            mem_rdata <= merged;
        end
    end

    a_r8_blocked_page_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !page_en[acc_page]) |-> !st_we);

    a_r12_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit));

    a_r12_commit_own_page: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> (mem_req && (st_waddr[ADDR_W-1 -: SEL_W] == acc_page)));

    a_r7_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n || !mrst_n)
        !rd_req |=> $stable(mem_rdata));
endmodule

// File: tb/sim_paged_wp_ram.sv
module sim_paged_wp_ram;
    logic        clk = 1'b0;
    logic        rst_n, mrst_n;
    logic        reg_sel, reg_wr;
    logic [1:0]  reg_size;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        reg_err;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata;
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    paged_wp_ram u0 (
        .clk(clk), .rst_n(rst_n), .mrst_n(mrst_n),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_size(reg_size),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_sel = 0; reg_wr = 0; reg_size = 0; reg_wdata = 0;
        mem_req = 0; mem_we = 0; mem_addr = 0; mem_be = 0; mem_wdata = 0;
    endtask

    // One register access; returns at the negedge after the capturing edge.
    task automatic reg_acc(input logic wr, input logic [1:0] sz, input logic [7:0] d);
        reg_sel = 1; reg_wr = wr; reg_size = sz; reg_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic mem_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        mem_req = 1; mem_we = 1; mem_addr = a; mem_be = be; mem_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic mem_rd(input logic [7:0] a);
        mem_req = 1; mem_we = 0; mem_addr = a;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        check("R1 reg_rdata after reset", reg_rdata, 0);
        check("R1 reg_err after reset", reg_err, 0);
        check("R1 mem_rdata after reset", mem_rdata, 0);
        reg_acc(0, 0, 0);
        check("R1 R3 register reads 0xFF", reg_rdata, 8'hFF);
    endtask

    task automatic t_forward_strobe();
        mem_wr(8'd5, 4'hF, 32'hA5A5_1234);
        mem_rd(8'd5);
        check("R9 next-cycle read of posted write", mem_rdata, 32'hA5A5_1234);
        mem_rd(8'd5);
        check("R7 committed word reads back", mem_rdata, 32'hA5A5_1234);
        mem_wr(8'd5, 4'b0011, 32'hFFFF_0000);
        mem_rd(8'd5);
        check("R11 only strobed bytes written", mem_rdata, 32'hA5A5_0000);
        @(negedge clk);
        check("R7 rdata holds without a read", mem_rdata, 32'hA5A5_0000);
    endtask

    task automatic t_register();
        reg_acc(1, 0, 8'h0A);
        reg_acc(0, 0, 0);
        check("R3 R4 byte write, reserved read as 1", reg_rdata, 8'hFA);
        reg_acc(1, 2, 8'h05);
        reg_acc(0, 0, 0);
        check("R4 word write ignored", reg_rdata, 8'hFA);
        reg_acc(1, 0, 8'h0F);
        reg_acc(0, 1, 0);
        check("R5 half read data zero", reg_rdata, 0);
        check("R5 error strobe raised", reg_err, 1);
        @(negedge clk);
        check("R5 error strobe one cycle", reg_err, 0);
    endtask

    task automatic t_protect();
        mem_wr(8'd67, 4'hF, 32'h1111_1111);
        mem_rd(8'd67);
        reg_acc(1, 0, 8'h0D);
        mem_wr(8'd67, 4'hF, 32'h2222_2222);
        mem_rd(8'd67);
        check("R8 write to blocked page dropped", mem_rdata, 32'h1111_1111);
        reg_acc(1, 0, 8'h0F);
        mem_rd(8'd67);
        check("R8 dropped write stays lost", mem_rdata, 32'h1111_1111);
    endtask

    task automatic t_strand();
        mem_wr(8'd130, 4'hF, 32'h3333_3333);
        mem_rd(8'd130);
        mem_wr(8'd130, 4'hF, 32'h4444_4444);
        reg_acc(1, 0, 8'h0B);
        mem_rd(8'd130);
        check("R8 stranded entry dropped", mem_rdata, 32'h3333_3333);
        mem_wr(8'd130, 4'hF, 32'h5555_5555);
        reg_acc(1, 0, 8'h0F);
        mem_rd(8'd130);
        check("R8 enable at commit time wins", mem_rdata, 32'h5555_5555);
    endtask

    task automatic t_independent();
        mem_wr(8'd200, 4'hF, 32'h6666_6666);
        mem_rd(8'd200);
        reg_acc(1, 0, 8'h07);
        mem_wr(8'd200, 4'hF, 32'h7777_7777);
        mem_wr(8'd10, 4'hF, 32'h0000_0010);
        mem_rd(8'd10);
        mem_rd(8'd130);
        reg_acc(1, 0, 8'h0F);
        mem_rd(8'd200);
        check("R12 R6 page 3 entry survived other pages", mem_rdata, 32'h7777_7777);
        reg_acc(1, 0, 8'h07);
        mem_wr(8'd255, 4'hF, 32'hDEAD_BEEF);
        mem_rd(8'd255);
        mem_rd(8'd200);
        check("R6 top word belongs to page 3", mem_rdata, 32'h7777_7777);
        mem_wr(8'd63, 4'hF, 32'h0BAD_CAFE);
        mem_rd(8'd63);
        check("R6 word 63 belongs to page 0", mem_rdata, 32'h0BAD_CAFE);
        reg_acc(1, 0, 8'h0F);
    endtask

    task automatic t_same_cycle();
        mem_wr(8'd12, 4'hF, 32'h8888_8888);
        reg_sel = 1; reg_wr = 1; reg_size = 0; reg_wdata = 8'h0E;
        mem_req = 1; mem_we = 0; mem_addr = 8'd12;
        @(negedge clk);
        idle();
        check("R10 same-cycle access uses old enable", mem_rdata, 32'h8888_8888);
        mem_rd(8'd12);
        check("R10 entry committed under old enable", mem_rdata, 32'h8888_8888);
        reg_acc(0, 0, 0);
        check("R10 new enable visible", reg_rdata, 8'hFE);
        reg_acc(1, 0, 8'h0F);
    endtask

    task automatic t_manual_reset();
        reg_acc(1, 0, 8'h07);
        mem_wr(8'd20, 4'hF, 32'h9999_9999);
        mem_rd(8'd20);
        mem_wr(8'd20, 4'hF, 32'hAAAA_AAAA);
        mrst_n = 0;
        @(negedge clk);
        mrst_n = 1;
        check("R2 manual reset clears rdata", mem_rdata, 0);
        reg_acc(0, 0, 0);
        check("R2 register kept over manual reset", reg_rdata, 8'hF7);
        mem_rd(8'd20);
        check("R2 pending write discarded", mem_rdata, 32'h9999_9999);
        reg_acc(1, 0, 8'h0F);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        rst_n = 0; mrst_n = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_forward_strobe();
        t_register();
        t_protect();
        t_strand();
        t_independent();
        t_same_cycle();
        t_manual_reset();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule